// File: doc/BRIEF.md
# Per-Quantum Engine Switching Controller

This block sits beside a core that holds two execution engines: a wide out-of-order engine and a narrow in-order engine. Only one of them runs at a time. After each quantum of retired instructions, the block gets the cycles-per-instruction (CPI) measured on the engine that just ran, together with a modelled CPI for the idle engine. From these it picks the engine for the next quantum. When that choice differs from the running engine, it asks for a switch.

The switch threshold is not a constant. A proportional-integral loop recomputes it every quantum. The target CPI is the big-engine CPI stretched by a user-set loss budget. The threshold then moves so that the achieved CPI follows that target. The gains, the loss budget and the limits of the integral term are held in small writable registers.

Top module: `engine_switch_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the select is big (`eng_sel` = 0), no switch is requested, the threshold reads 0 and the integral accumulator is 0. The defaults are Kp = 0x0100, Ki = 0x0020, loss = 5, upper limit = 16384 and lower limit = -16384.
- R2: At a decision, the little engine (`eng_sel` = 1) is chosen when (little CPI - big CPI) as a signed value is less than or equal to the threshold produced by that same decision. Otherwise the big engine (`eng_sel` = 0) is chosen, so a difference equal to the threshold picks little.
- R3: The new threshold is (Kp*err + Ki*acc) arithmetically shifted right by 8, saturated to a 24-bit signed range. Kp and Ki are signed Q8.8, and acc is the accumulator value after this decision's update.
- R4: err = target - `cpi_meas`, and target = big + floor(big * L * 655 / 65536), where L is the loss budget in percent. All CPI values are unsigned Q8.8.
- R5: When big is running, `cpi_meas` is the big CPI and `cpi_est` is the little CPI. When little is running, the two roles swap.
- R6: Each decision sets the accumulator to acc + err, clamped to the range [lower limit, upper limit].
- R7: `sw_req` rises at a decision only when the chosen engine differs from the running engine. It stays high until a cycle in which `sw_done` is 1. After that cycle it is low, and the chosen engine becomes the running engine.
- R8: A `quantum_done` pulse that arrives while `sw_req` is high is ignored. The threshold, the accumulator and the select do not change.
- R9: Configuration writes use `cfg_addr` 0 for Kp (low 16 bits), 1 for Ki (low 16 bits), 2 for loss percent, 3 for the upper limit and 4 for the lower limit (24-bit signed). A loss value below 1 is stored as 1 and a value above 20 is stored as 20. Writes to addresses 5 to 7 have no effect. A write takes effect for decisions made in later cycles.
- R10: A decision happens only in a cycle where `quantum_done` is 1. In other cycles `eng_sel` and `thresh` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| quantum_done | input | 1 | One-cycle pulse at the end of a quantum |
| cpi_meas | input | 16 | Measured CPI of the running engine, Q8.8 |
| cpi_est | input | 16 | Modelled CPI of the idle engine, Q8.8 |
| sw_done | input | 1 | Acknowledgment that the requested switch has finished |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 24 | Configuration write data |
| eng_sel | output | 1 | Engine for the next quantum, 0 = big, 1 = little |
| sw_req | output | 1 | Switch request, held until acknowledged |
| thresh | output | 24 | Current signed threshold, Q8.8 |

## Verification
The hardest states to reach from the ports are the two ends of the clamped accumulator. An accumulator that already lies outside newly written limits is also hard to reach. The bench sets Kp to zero and Ki to one, so the threshold port shows the accumulator directly. It builds a negative balance first, narrows the limits, and then repeats quanta with a fixed positive error until the upper limit holds. A second hard case is a quantum that arrives while a switch is pending: the bench holds back the acknowledgment and sends a quantum with extreme CPI values in that window. A long pseudo-random phase with random acknowledgment delays is then compared every cycle against a behavioural model.

// File: rtl/esc_pkg.sv
// Shared types and constants for the engine switching controller.
// Assumes CPI values in unsigned Q8.8 and a loss budget in whole percent.
package esc_pkg;

    typedef enum logic {
        ENG_BIG    = 1'b0,
        ENG_LITTLE = 1'b1
    } engine_e;

    // configuration register map
    localparam logic [2:0] CFG_KP     = 3'd0;
    localparam logic [2:0] CFG_KI     = 3'd1;
    localparam logic [2:0] CFG_LOSS   = 3'd2;
    localparam logic [2:0] CFG_LIM_HI = 3'd3;
    localparam logic [2:0] CFG_LIM_LO = 3'd4;

    // loss percent to Q0.16 fraction: L*655/65536 ~ L/100
    localparam int LOSS_SCALE   = 655;
    localparam int LOSS_SHIFT   = 16;
    localparam int LOSS_MIN     = 1;
    localparam int LOSS_MAX     = 20;
    localparam int LOSS_DEFAULT = 5;

endpackage

// File: rtl/esc_cfg_regs.sv
// Configuration register bank: gains, loss budget and accumulator limits.
// Assumes a single-cycle write strobe; unmapped addresses are dropped and
// the loss budget is clamped into its supported range on write.
module esc_cfg_regs
    import esc_pkg::*;
#(
    parameter int GAIN_W = 16,
    parameter int ACC_W  = 24,
    parameter int LOSS_W = 5,
    parameter int KP_RST = 256,
    parameter int KI_RST = 32,
    parameter int LIM_RST = 16384
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [2:0]               cfg_addr,
    input  logic [ACC_W-1:0]         cfg_wdata,
    output logic signed [GAIN_W-1:0] kp,
    output logic signed [GAIN_W-1:0] ki,
    output logic [LOSS_W-1:0]        loss_pct,
    output logic signed [ACC_W-1:0]  lim_hi,
    output logic signed [ACC_W-1:0]  lim_lo
);

    localparam logic [ACC_W-1:0] W_LOSS_MIN = ACC_W'(LOSS_MIN);
    localparam logic [ACC_W-1:0] W_LOSS_MAX = ACC_W'(LOSS_MAX);

    logic [LOSS_W-1:0] loss_clamped;

    // bound the written loss budget to the supported range
    always_comb begin
        if (cfg_wdata < W_LOSS_MIN)
            loss_clamped = LOSS_W'(LOSS_MIN);
        else if (cfg_wdata > W_LOSS_MAX)
            loss_clamped = LOSS_W'(LOSS_MAX);
        else
            loss_clamped = cfg_wdata[LOSS_W-1:0];
    end

    // register writes with reset defaults
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kp       <= GAIN_W'(KP_RST);
            ki       <= GAIN_W'(KI_RST);
            loss_pct <= LOSS_W'(LOSS_DEFAULT);
            lim_hi   <= ACC_W'(LIM_RST);
            lim_lo   <= -(ACC_W'(LIM_RST));
        end else if (cfg_we) begin
            case (cfg_addr)
                CFG_KP:     kp       <= cfg_wdata[GAIN_W-1:0];
                CFG_KI:     ki       <= cfg_wdata[GAIN_W-1:0];
                CFG_LOSS:   loss_pct <= loss_clamped;
                CFG_LIM_HI: lim_hi   <= cfg_wdata;
                CFG_LIM_LO: lim_lo   <= cfg_wdata;
                default: ;
            endcase
        end
    end

    // R9: stored loss budget always within the supported range
    p_loss_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (loss_pct >= LOSS_W'(LOSS_MIN)) && (loss_pct <= LOSS_W'(LOSS_MAX)));

endmodule

// File: rtl/esc_error_calc.sv
// Combinational front end: assigns measured and modelled CPI to the big and
// little engines, forms the target CPI from the loss budget, the CPI error
// and the little-minus-big difference. Assumes unsigned Q8.8 inputs.
module esc_error_calc
    import esc_pkg::*;
#(
    parameter int CPI_W  = 16,
    parameter int LOSS_W = 5,
    parameter int ERR_W  = CPI_W + 3,
    parameter int DIFF_W = CPI_W + 1
) (
    input  engine_e                  active,
    input  logic [CPI_W-1:0]         cpi_meas,
    input  logic [CPI_W-1:0]         cpi_est,
    input  logic [LOSS_W-1:0]        loss_pct,
    output logic signed [ERR_W-1:0]  err,
    output logic signed [DIFF_W-1:0] diff
);

    localparam int LK_W   = LOSS_W + 10;
    localparam int PR_W   = CPI_W + LK_W;
    localparam int TGT_W  = CPI_W + 1;

    logic [CPI_W-1:0] big_cpi;
    logic [CPI_W-1:0] little_cpi;
    logic [LK_W-1:0]  loss_k;
    logic [TGT_W-1:0] target;

    // route measured value to the running engine, model to the idle one
    always_comb begin
        if (active == ENG_BIG) begin
            big_cpi    = cpi_meas;
            little_cpi = cpi_est;
        end else begin
            big_cpi    = cpi_est;
            little_cpi = cpi_meas;
        end
    end

    // loss fraction in Q0.16 and stretched big-engine CPI as target
    assign loss_k = LK_W'(loss_pct) * LK_W'(LOSS_SCALE);
    assign target = TGT_W'(big_cpi) +
                    TGT_W'((PR_W'(big_cpi) * PR_W'(loss_k)) >> LOSS_SHIFT);

    // signed error and engine CPI difference
    assign err  = $signed(ERR_W'(target)) - $signed(ERR_W'(cpi_meas));
    assign diff = $signed(DIFF_W'(little_cpi)) - $signed(DIFF_W'(big_cpi));

endmodule

// File: rtl/esc_pi_loop.sv
// Proportional-integral threshold loop. On each accepted decision it adds
// the error into a clamped accumulator and forms the saturated threshold.
// The next-threshold value is also exported for the decision in that cycle.
module esc_pi_loop #(
    parameter int GAIN_W = 16,
    parameter int ERR_W  = 19,
    parameter int ACC_W  = 24,
    parameter int TH_W   = 24,
    parameter int FRAC   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fire,
    input  logic                     cfg_quiet,
    input  logic signed [ERR_W-1:0]  err,
    input  logic signed [GAIN_W-1:0] kp,
    input  logic signed [GAIN_W-1:0] ki,
    input  logic signed [ACC_W-1:0]  lim_hi,
    input  logic signed [ACC_W-1:0]  lim_lo,
    output logic signed [TH_W-1:0]   th_next,
    output logic signed [TH_W-1:0]   thresh
);

    localparam int SUM_W  = ACC_W + 1;
    localparam int PROD_W = GAIN_W + ACC_W + 1;
    localparam logic signed [PROD_W-1:0] TH_MAX = PROD_W'((2 ** (TH_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] TH_MIN = -TH_MAX - PROD_W'(1);

    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  acc_next;
    logic signed [SUM_W-1:0]  acc_sum;
    logic signed [PROD_W-1:0] mix;
    logic signed [PROD_W-1:0] mix_sh;

    // accumulate the error and clamp to the programmed limits
    always_comb begin
        acc_sum = SUM_W'(acc) + SUM_W'(err);
        if (acc_sum > SUM_W'(lim_hi))
            acc_next = lim_hi;
        else if (acc_sum < SUM_W'(lim_lo))
            acc_next = lim_lo;
        else
            acc_next = acc_sum[ACC_W-1:0];
    end

    // weighted sum of both terms, rescaled and saturated
    always_comb begin
        mix    = (PROD_W'(kp) * PROD_W'(err)) + (PROD_W'(ki) * PROD_W'(acc_next));
        mix_sh = mix >>> FRAC;
        if (mix_sh > TH_MAX)
            th_next = TH_MAX[TH_W-1:0];
        else if (mix_sh < TH_MIN)
            th_next = TH_MIN[TH_W-1:0];
        else
            th_next = mix_sh[TH_W-1:0];
    end

    // update loop state only on accepted decisions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            thresh <= '0;
        end else if (fire) begin
            acc    <= acc_next;
            thresh <= th_next;
        end
    end

    // R6: after an update with consistent limits the accumulator is in range
    p_acc_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cfg_quiet && (lim_lo <= lim_hi) |=> (acc <= lim_hi) && (acc >= lim_lo));

    // R10: the threshold register moves only at an accepted decision
    p_thresh_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(thresh));

endmodule

// File: rtl/esc_switch_fsm.sv
// Engine selection and switch handshake. Holds the chosen engine and the
// running engine; raises a request when they differ and waits for the ack.
module esc_switch_fsm
    import esc_pkg::*;
#(
    parameter int TH_W   = 24,
    parameter int DIFF_W = 17
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fire,
    input  logic                     sw_done,
    input  logic signed [DIFF_W-1:0] diff,
    input  logic signed [TH_W-1:0]   th_next,
    output engine_e                  sel,
    output engine_e                  active,
    output logic                     sw_req
);

    engine_e want;

    // little engine wins when its CPI penalty fits under the threshold
    always_comb begin
        want = (TH_W'(diff) <= th_next) ? ENG_LITTLE : ENG_BIG;
    end

    // selection, running engine and request register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel    <= ENG_BIG;
            active <= ENG_BIG;
            sw_req <= 1'b0;
        end else if (sw_req) begin
            if (sw_done) begin
                active <= sel;
                sw_req <= 1'b0;
            end
        end else if (fire) begin
            sel    <= want;
            sw_req <= (want != active);
        end
    end

    // R7: pending request stays until acknowledged
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req && !sw_done |=> sw_req);

    // R7: an acknowledgment clears the request
    p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req && sw_done |=> !sw_req);

    // R7: a new request always comes with a changed selection
    p_req_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_req) |-> (sel != $past(sel)));

endmodule

// File: rtl/engine_switch_ctrl.sv
// Top of the per-quantum engine switching controller. Ties the register
// bank, the error front end, the PI threshold loop and the switch handshake.
// Assumes quantum_done is a single-cycle pulse per quantum boundary.
module engine_switch_ctrl
    import esc_pkg::*;
#(
    parameter int CPI_W  = 16,
    parameter int GAIN_W = 16,
    parameter int ACC_W  = 24,
    parameter int TH_W   = 24,
    parameter int LOSS_W = 5,
    parameter int FRAC   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   quantum_done,
    input  logic [CPI_W-1:0]       cpi_meas,
    input  logic [CPI_W-1:0]       cpi_est,
    input  logic                   sw_done,
    input  logic                   cfg_we,
    input  logic [2:0]             cfg_addr,
    input  logic [ACC_W-1:0]       cfg_wdata,
    output logic                   eng_sel,
    output logic                   sw_req,
    output logic signed [TH_W-1:0] thresh
);

    localparam int ERR_W  = CPI_W + 3;
    localparam int DIFF_W = CPI_W + 1;

    logic signed [GAIN_W-1:0] kp;
    logic signed [GAIN_W-1:0] ki;
    logic [LOSS_W-1:0]        loss_pct;
    logic signed [ACC_W-1:0]  lim_hi;
    logic signed [ACC_W-1:0]  lim_lo;
    logic signed [ERR_W-1:0]  err;
    logic signed [DIFF_W-1:0] diff;
    logic signed [TH_W-1:0]   th_next;
    engine_e                  sel;
    engine_e                  active;
    logic                     fire;

    // decisions are taken only when no switch is outstanding
    assign fire    = quantum_done && !sw_req;
    assign eng_sel = sel;

    esc_cfg_regs #(
        .GAIN_W (GAIN_W),
        .ACC_W  (ACC_W),
        .LOSS_W (LOSS_W)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .kp        (kp),
        .ki        (ki),
        .loss_pct  (loss_pct),
        .lim_hi    (lim_hi),
        .lim_lo    (lim_lo)
    );

    esc_error_calc #(
        .CPI_W  (CPI_W),
        .LOSS_W (LOSS_W),
        .ERR_W  (ERR_W),
        .DIFF_W (DIFF_W)
    ) calc_i (
        .active   (active),
        .cpi_meas (cpi_meas),
        .cpi_est  (cpi_est),
        .loss_pct (loss_pct),
        .err      (err),
        .diff     (diff)
    );

    esc_pi_loop #(
        .GAIN_W (GAIN_W),
        .ERR_W  (ERR_W),
        .ACC_W  (ACC_W),
        .TH_W   (TH_W),
        .FRAC   (FRAC)
    ) pi_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .cfg_quiet (!cfg_we),
        .err       (err),
        .kp        (kp),
        .ki        (ki),
        .lim_hi    (lim_hi),
        .lim_lo    (lim_lo),
        .th_next   (th_next),
        .thresh    (thresh)
    );

    esc_switch_fsm #(
        .TH_W   (TH_W),
        .DIFF_W (DIFF_W)
    ) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .sw_done (sw_done),
        .diff    (diff),
        .th_next (th_next),
        .sel     (sel),
        .active  (active),
        .sw_req  (sw_req)
    );

    // R8: a quantum arriving during a pending switch leaves outputs untouched
    p_ignore_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_req && quantum_done |=> $stable(thresh) && $stable(eng_sel));

    // R10: without a quantum boundary the selection holds
    p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !quantum_done |=> $stable(eng_sel));

    // R1: reset leaves big selected and nothing requested
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> !sw_req && !eng_sel && (thresh == '0));

endmodule

// File: tb/engine_switch_ctrl_tb_top.sv
// Bench for engine_switch_ctrl: a behavioural integer model, compared on
// every clock, plus directed checks on boundary values.
module engine_switch_ctrl_tb_top;

    localparam int CLK_P = 10;
    localparam int WDOG  = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        quantum_done = 1'b0;
    logic [15:0] cpi_meas = '0;
    logic [15:0] cpi_est = '0;
    logic        sw_done = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0;
    logic        eng_sel;
    logic        sw_req;
    logic signed [23:0] thresh;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    longint m_kp, m_ki, m_loss, m_hi, m_lo, m_acc, m_th;
    int     m_sel, m_act, m_req;

    always #(CLK_P/2) clk = ~clk;

    engine_switch_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .quantum_done (quantum_done),
        .cpi_meas     (cpi_meas),
        .cpi_est      (cpi_est),
        .sw_done      (sw_done),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .eng_sel      (eng_sel),
        .sw_req       (sw_req),
        .thresh       (thresh)
    );

    task automatic check(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic longint sext24(input logic [23:0] v);
        return longint'($signed(v));
    endfunction

    // behavioural model advanced on every clock edge
    always @(posedge clk) begin
        longint big, lit, tgt, err, sum, th, diff;
        int want;
        if (!rst_n) begin
            m_kp = 256; m_ki = 32; m_loss = 5; m_hi = 16384; m_lo = -16384;
            m_acc = 0; m_th = 0; m_sel = 0; m_act = 0; m_req = 0;
        end else begin
            if (m_req == 1) begin
                if (sw_done) begin
                    m_act = m_sel;
                    m_req = 0;
                end
            end else if (quantum_done) begin
                big  = (m_act == 0) ? longint'(cpi_meas) : longint'(cpi_est);
                lit  = (m_act == 0) ? longint'(cpi_est) : longint'(cpi_meas);
                tgt  = big + ((big * m_loss * 655) >>> 16);
                err  = tgt - longint'(cpi_meas);
                sum  = m_acc + err;
                if (sum > m_hi) sum = m_hi;
                else if (sum < m_lo) sum = m_lo;
                m_acc = sum;
                th = (m_kp * err + m_ki * m_acc) >>> 8;
                if (th > 8388607) th = 8388607;
                if (th < -8388608) th = -8388608;
                m_th = th;
                diff = lit - big;
                want = (diff <= th) ? 1 : 0;
                m_sel = want;
                if (want != m_act) m_req = 1;
            end
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: m_kp = longint'($signed(cfg_wdata[15:0]));
                    3'd1: m_ki = longint'($signed(cfg_wdata[15:0]));
                    3'd2: m_loss = (cfg_wdata < 1) ? 1 : ((cfg_wdata > 20) ? 20 : longint'(cfg_wdata));
                    3'd3: m_hi = sext24(cfg_wdata);
                    3'd4: m_lo = sext24(cfg_wdata);
                    default: ;
                endcase
            end
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 eng_sel vs model", longint'(eng_sel), longint'(m_sel));
            check("R7 sw_req vs model", longint'(sw_req), longint'(m_req));
            check("R3 thresh vs model", longint'(thresh), m_th);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles >= WDOG) begin
            errors++;
            $display("FAIL watchdog expired got=%0d exp<%0d", cycles, WDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    task automatic quantum(input int meas, input int est);
        step();
        quantum_done = 1'b1;
        cpi_meas = 16'(meas);
        cpi_est = 16'(est);
        step();
        quantum_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic cfg_write(input int addr, input int data);
        step();
        cfg_we = 1'b1;
        cfg_addr = 3'(addr);
        cfg_wdata = 24'(data);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic ack();
        step();
        sw_done = 1'b1;
        step();
        sw_done = 1'b0;
        @(negedge clk);
    endtask

    int lcg = 12345;
    function automatic int rnd(input int mod);
        lcg = lcg * 1103515245 + 12345;
        return ((lcg >>> 8) & 32'h7fffff) % mod;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 eng_sel after reset", longint'(eng_sel), 0);
        check("R1 sw_req after reset", longint'(sw_req), 0);
        check("R1 thresh after reset", longint'(thresh), 0);

        // R9 clamp of loss budget, threshold equals error with Kp=1, Ki=0
        cfg_write(1, 0);
        cfg_write(2, 31);
        quantum(4096, 9999);
        check("R9 loss clamp high (R4 target)", longint'(thresh), 818);
        check("R7 no request when same engine", longint'(sw_req), 0);
        cfg_write(2, 0);
        cfg_write(7, 999);
        quantum(4096, 9999);
        check("R9 loss clamp low, bad addr ignored", longint'(thresh), 40);

        // R2 equality boundary with loss 5
        cfg_write(2, 5);
        quantum(4096, 4096 + 205);
        check("R2 diff above threshold picks big", longint'(eng_sel), 0);
        check("R3 threshold value", longint'(thresh), 204);
        quantum(4096, 4096 + 204);
        check("R2 diff equal threshold picks little", longint'(eng_sel), 1);
        check("R7 request raised on change", longint'(sw_req), 1);

        // R8 quantum while pending is ignored
        quantum(4096, 60000);
        check("R8 thresh unchanged while pending", longint'(thresh), 204);
        check("R8 select unchanged while pending", longint'(eng_sel), 1);
        check("R7 request held without ack", longint'(sw_req), 1);
        ack();
        check("R7 request cleared by ack", longint'(sw_req), 0);

        // R5 running little: measured is little, modelled is big
        quantum(4096, 2000);
        check("R5 roles swap when little runs", longint'(thresh), -1997);
        check("R5 back to big", longint'(eng_sel), 0);
        ack();

        // R6 accumulator clamp: Kp=0, Ki=1.0 exposes accumulator
        cfg_write(0, 0);
        cfg_write(1, 256);
        cfg_write(3, 1000);
        cfg_write(4, 24'hFFFE0C); // -500
        quantum(4096, 65535);
        check("R6 lower clamp", longint'(thresh), -500);
        for (int i = 0; i < 10; i++) quantum(4096, 65535);
        check("R6 upper clamp", longint'(thresh), 1000);

        // R10 no quantum: outputs hold
        repeat (5) step();
        @(negedge clk);
        check("R10 thresh holds without quantum", longint'(thresh), 1000);

        // pseudo-random phase against the model
        cfg_write(0, 256);
        cfg_write(1, 32);
        cfg_write(3, 16384);
        cfg_write(4, 24'hFFC000);
        for (int n = 0; n < 400; n++) begin
            if (rnd(8) == 0) cfg_write(2, rnd(25));
            quantum(200 + rnd(3000), 200 + rnd(3000));
            if (sw_req) begin
                repeat (rnd(4)) step();
                if (rnd(2) == 0) quantum(rnd(65536), rnd(65536));
                ack();
            end
        end

        // R1 reset mid-run
        step();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sel after second reset", longint'(eng_sel), 0);
        check("R1 thresh after second reset", longint'(thresh), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule